// File: doc/BRIEF.md
# Flash Command Key Lock

This block guards the protected functions of a flash controller behind a 32-bit unlock key that software writes. It has three write strobes: one for the key register, one for the command register and one for the user configuration register. A two-state machine holds the lock state, and the protected paths use it as their qualifier. A command is judged against that state and passed downstream only when it is allowed. Configuration writes go through only while the lock is open.

The lock opens when the exact key 0x676C7565 is written. It stays open across any number of other writes until one of two things happens. Either a different value lands in the key register, or any command is written. Every command write closes the lock, whether that command needs the key or not, so each protected operation needs a fresh key. The key register always reads back as zero. Only the lock flag is visible. A protected command attempted while the lock is closed is refused and sets a sticky violation bit.

States: `ST_SEALED` (the reset state, key invalid) and `ST_OPEN` (key valid). Transitions: `T_UNSEAL` goes from SEALED to OPEN on a correct key write with no command write in the same cycle. `T_RESEAL_KEY` goes from OPEN to SEALED on a wrong key write. `T_RESEAL_CMD` goes from OPEN to SEALED on any command write. Every other cycle is a hold.

Top module: `flash_key_lock`

## Requirements
- R1: After reset the lock is closed (`unlocked` = 0). Only a key write of exactly 32'h676C7565 opens it, and `unlocked` reads 1 from the first cycle after that write.
- R2: Command codes 1 (page erase), 2 (signature), 3 (mass erase) and 4 (abort) are protected. Written while the lock is open, a protected command gives a one-cycle `cmd_accept` and `cmd_go` pulse, with `cmd_go_code` equal to the code. Written while the lock is closed, it gives a one-cycle `cmd_reject` and no `cmd_go`.
- R3: Writes to the configuration register and repeated correct key writes leave an open lock open.
- R4: A configuration write appears on `cfg_we_out` and `cfg_wdata_out` one cycle later only if the lock was open when it was written. Otherwise it is dropped.
- R5: Any command write closes the lock, including an unprotected code such as 0 or 5. An unprotected command is always accepted.
- R6: A key write of any value other than the key closes the lock, including a value that differs from the key in a single bit.
- R7: A rejected protected command sets `access_viol`. The bit stays set until reset.
- R8: When a key write and a command write arrive in the same cycle, the command is judged on the lock state before that cycle, and the lock is closed afterwards. A key write in the same cycle as a configuration write does not qualify that configuration write.
- R9: `key_rdata` is always zero, so the stored key is never exposed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_wr_en | input | 1 | Key register write strobe |
| key_wr_data | input | 32 | Value written to the key register |
| cmd_wr_en | input | 1 | Command register write strobe |
| cmd_wr_code | input | 4 | Command code written |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_wr_data | input | 32 | Configuration write data |
| unlocked | output | 1 | Lock open (key valid) |
| key_rdata | output | 32 | Key register read value, always zero |
| cmd_go | output | 1 | One-cycle start pulse for an accepted command |
| cmd_go_code | output | 4 | Code of the command being started |
| cmd_accept | output | 1 | Command accepted pulse |
| cmd_reject | output | 1 | Protected command refused pulse |
| access_viol | output | 1 | Sticky violation flag |
| cfg_we_out | output | 1 | Qualified configuration write enable |
| cfg_wdata_out | output | 32 | Configuration write data, forwarded |

## Verification
A lock state that is wrong inside the block appears on `unlocked` in the very next cycle. It also flips the verdict of the next protected command or configuration write: an accept where a reject is expected, or a forwarded write where the write should be dropped. The bench therefore checks every output one cycle after each write. Its sequences put the lock in each state before the stimulus that should change it, so a missed or extra transition is caught before any later write can hide it. The same-cycle key and command cases show whether the verdict uses the old lock state or the new one.

// File: rtl/flk_pkg.sv
package flk_pkg;

    localparam int KEY_W  = 32;
    localparam int CODE_W = 4;
    localparam logic [KEY_W-1:0] UNLOCK_KEY = 32'h676C7565;

    typedef enum logic {
        ST_SEALED = 1'b0,
        ST_OPEN   = 1'b1
    } lock_state_t;

    typedef enum logic [1:0] {
        T_HOLD       = 2'd0,
        T_UNSEAL     = 2'd1,
        T_RESEAL_KEY = 2'd2,
        T_RESEAL_CMD = 2'd3
    } lock_move_t;

endpackage

// File: rtl/flk_key_match.sv
module flk_key_match
    import flk_pkg::*;
#(
    parameter int                 W   = KEY_W,
    parameter logic [W-1:0]       KEY = UNLOCK_KEY
) (
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         good_key,
    output logic         bad_key
);
    logic [W-1:0] diff;

    always_comb begin
        diff     = wr_data ^ KEY;
        good_key = wr_en && (diff == '0);
        bad_key  = wr_en && (diff != '0);
    end
endmodule

// File: rtl/flk_lock_fsm.sv
module flk_lock_fsm
    import flk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic good_key,
    input  logic bad_key,
    input  logic cmd_wr,
    output logic is_open
);
    lock_state_t state_q, state_d;
    lock_move_t  move;

    // next-state selection
    always_comb begin
        move    = T_HOLD;
        state_d = state_q;
        unique case (state_q)
            ST_SEALED: begin
                if (good_key && !cmd_wr) begin
                    move    = T_UNSEAL;
                    state_d = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (cmd_wr) begin
                    move    = T_RESEAL_CMD;
                    state_d = ST_SEALED;
                end else if (bad_key) begin
                    move    = T_RESEAL_KEY;
                    state_d = ST_SEALED;
                end
            end
            default: begin
                move    = T_HOLD;
                state_d = ST_SEALED;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SEALED;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_OPEN:   is_open = 1'b1;
            ST_SEALED: is_open = 1'b0;
            default:   is_open = 1'b0;
        endcase
    end

    assert_cmd_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> !is_open);
    assert_bad_key_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_key |=> !is_open);
    assert_open_persists_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_open && !cmd_wr && !bad_key) |=> is_open);
    assert_good_key_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (good_key && !cmd_wr) |=> is_open);
    assert_move_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (move == T_UNSEAL) |-> !is_open);
endmodule

// File: rtl/flk_cmd_gate.sv
module flk_cmd_gate
    import flk_pkg::*;
#(
    parameter int                     CW        = CODE_W,
    parameter logic [(1<<CW)-1:0]     PROT_MASK = 16'h001E
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic [CW-1:0] cmd_code,
    input  logic          is_open,
    output logic          go,
    output logic [CW-1:0] go_code,
    output logic          accept,
    output logic          reject,
    output logic          viol
);
    localparam int NCODES = 1 << CW;

    logic [NCODES-1:0] hit;
    logic              needs_key;
    logic              allow, refuse;

    // one-hot decode of the code, masked by the protected set
    for (genvar g = 0; g < NCODES; g++) begin : g_dec
        assign hit[g] = (cmd_code == CW'(g)) && PROT_MASK[g];
    end

    always_comb begin
        needs_key = |hit;
        allow     = cmd_wr && (!needs_key || is_open);
        refuse    = cmd_wr && needs_key && !is_open;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go      <= 1'b0;
            go_code <= '0;
            accept  <= 1'b0;
            reject  <= 1'b0;
            viol    <= 1'b0;
        end else begin
            go      <= allow;
            go_code <= allow ? cmd_code : '0;
            accept  <= allow;
            reject  <= refuse;
            if (refuse) viol <= 1'b1;
        end
    end

    assert_verdict_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && reject));
    assert_no_go_on_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> !go);
    assert_viol_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> viol);
    assert_reject_sets_viol_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> viol);
    assert_prior_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && needs_key && is_open) |=> accept);
endmodule

// File: rtl/flk_cfg_gate.sv
module flk_cfg_gate #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [DW-1:0] cfg_data,
    input  logic          is_open,
    output logic          we_out,
    output logic [DW-1:0] wdata_out
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_out    <= 1'b0;
            wdata_out <= '0;
        end else begin
            we_out <= cfg_wr && is_open;
            if (cfg_wr && is_open) wdata_out <= cfg_data;
        end
    end

    assert_cfg_needs_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !is_open) |=> !we_out);
    assert_cfg_passes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && is_open) |=> (we_out && wdata_out == $past(cfg_data)));
endmodule

// File: rtl/flash_key_lock.sv
module flash_key_lock
    import flk_pkg::*;
#(
    parameter int                 KW        = KEY_W,
    parameter int                 CW        = CODE_W,
    parameter int                 DW        = 32,
    parameter logic [KW-1:0]      KEY       = UNLOCK_KEY,
    parameter logic [(1<<CW)-1:0] PROT_MASK = 16'h001E
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_wr_en,
    input  logic [KW-1:0] key_wr_data,
    input  logic          cmd_wr_en,
    input  logic [CW-1:0] cmd_wr_code,
    input  logic          cfg_wr_en,
    input  logic [DW-1:0] cfg_wr_data,
    output logic          unlocked,
    output logic [KW-1:0] key_rdata,
    output logic          cmd_go,
    output logic [CW-1:0] cmd_go_code,
    output logic          cmd_accept,
    output logic          cmd_reject,
    output logic          access_viol,
    output logic          cfg_we_out,
    output logic [DW-1:0] cfg_wdata_out
);
    logic good_key, bad_key, is_open;

    flk_key_match #(.W(KW), .KEY(KEY)) u_match (
        .wr_en    (key_wr_en),
        .wr_data  (key_wr_data),
        .good_key (good_key),
        .bad_key  (bad_key)
    );

    flk_lock_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .good_key (good_key),
        .bad_key  (bad_key),
        .cmd_wr   (cmd_wr_en),
        .is_open  (is_open)
    );

    flk_cmd_gate #(.CW(CW), .PROT_MASK(PROT_MASK)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr_en),
        .cmd_code (cmd_wr_code),
        .is_open  (is_open),
        .go       (cmd_go),
        .go_code  (cmd_go_code),
        .accept   (cmd_accept),
        .reject   (cmd_reject),
        .viol     (access_viol)
    );

    flk_cfg_gate #(.DW(DW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr_en),
        .cfg_data  (cfg_wr_data),
        .is_open   (is_open),
        .we_out    (cfg_we_out),
        .wdata_out (cfg_wdata_out)
    );

    assign unlocked  = is_open;
    assign key_rdata = '0; // R9: stored key never exposed
endmodule

// File: tb/tb_flash_key_lock.sv
module tb_flash_key_lock;
    localparam logic [31:0] K = 32'h676C7565;
    localparam logic [31:0] W = 32'h12345678;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_wr_en = 1'b0;
    logic [31:0] key_wr_data = '0;
    logic        cmd_wr_en = 1'b0;
    logic [3:0]  cmd_wr_code = '0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic        unlocked, cmd_go, cmd_accept, cmd_reject, access_viol, cfg_we_out;
    logic [31:0] key_rdata, cfg_wdata_out;
    logic [3:0]  cmd_go_code;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk; // 125 MHz

    flash_key_lock dut (.*);

    typedef struct packed {
        logic        ke;
        logic [31:0] kd;
        logic        ce;
        logic [3:0]  cc;
        logic        fe;
        logic        unl;
        logic        acc;
        logic        rej;
        logic        cfg;
        logic        viol;
        logic [3:0]  rq;
    } vec_t;

    // ke kd ce cc fe | unl acc rej cfg viol | req
    localparam vec_t VECS [18] = '{
        '{1'b0, 32'h0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4}, // R4 cfg while locked
        '{1'b1, W,     1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6}, // R6
        '{1'b1, K,     1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1}, // R1
        '{1'b0, 32'h0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd4}, // R4 cfg while open
        '{1'b0, 32'h0, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 idle
        '{1'b1, K,     1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 repeat key
        '{1'b0, 32'h0, 1'b1, 4'd5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5}, // R5 unprotected
        '{1'b0, 32'h0, 1'b1, 4'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7}, // R7 erase locked
        '{1'b1, K,     1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1},
        '{1'b0, 32'h0, 1'b1, 4'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2}, // R2 sign
        '{1'b1, K,     1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1},
        '{1'b1, W,     1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},
        '{1'b0, 32'h0, 1'b1, 4'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd2}, // R2 mass erase
        '{1'b1, K,     1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1},
        '{1'b1, W,     1'b1, 4'd4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd8}, // R8 abort
        '{1'b1, K,     1'b1, 4'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd8}, // R8
        '{1'b1, K,     1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8}, // R8 cfg
        '{1'b0, 32'h0, 1'b1, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd5}  // R5 nop
    };

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic apply(input logic ke, input logic [31:0] kd, input logic ce,
                         input logic [3:0] cc, input logic fe, input logic [31:0] fd);
        key_wr_en = ke; key_wr_data = kd;
        cmd_wr_en = ce; cmd_wr_code = cc;
        cfg_wr_en = fe; cfg_wr_data = fd;
        @(posedge clk);
        @(negedge clk);
        key_wr_en = 1'b0; cmd_wr_en = 1'b0; cfg_wr_en = 1'b0;
    endtask

    initial begin
        fork
            begin : wd
                repeat (5000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
            begin : body
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                // reset state (R1, R9)
                check("R1", "unlocked after reset", 32'(unlocked), 32'd0);
                check("R2", "accept after reset", 32'(cmd_accept), 32'd0);
                check("R7", "viol after reset", 32'(access_viol), 32'd0);
                check("R4", "cfg_we after reset", 32'(cfg_we_out), 32'd0);

                foreach (VECS[i]) begin
                    string t;
                    t = $sformatf("R%0d", VECS[i].rq);
                    apply(VECS[i].ke, VECS[i].kd, VECS[i].ce, VECS[i].cc,
                          VECS[i].fe, 32'hA5A50000 + 32'(i));
                    check(t, $sformatf("v%0d unlocked", i), 32'(unlocked), 32'(VECS[i].unl));
                    check(t, $sformatf("v%0d accept", i), 32'(cmd_accept), 32'(VECS[i].acc));
                    check(t, $sformatf("v%0d go", i), 32'(cmd_go), 32'(VECS[i].acc));
                    check(t, $sformatf("v%0d reject", i), 32'(cmd_reject), 32'(VECS[i].rej));
                    check(t, $sformatf("v%0d cfg_we", i), 32'(cfg_we_out), 32'(VECS[i].cfg));
                    check(t, $sformatf("v%0d viol", i), 32'(access_viol), 32'(VECS[i].viol));
                    if (VECS[i].acc)
                        check("R2", $sformatf("v%0d go code", i), 32'(cmd_go_code), 32'(VECS[i].cc));
                    if (VECS[i].cfg)
                        check("R4", $sformatf("v%0d cfg data", i), cfg_wdata_out, 32'hA5A50000 + 32'(i));
                end

                // pulses last one cycle (R2)
                apply(1'b1, K, 1'b0, 4'd0, 1'b0, 32'h0);
                apply(1'b0, 32'h0, 1'b1, 4'd4, 1'b0, 32'h0);
                @(negedge clk);
                check("R2", "accept pulse ends", 32'(cmd_accept), 32'd0);
                // key readback while open (R9)
                apply(1'b1, K, 1'b0, 4'd0, 1'b0, 32'h0);
                check("R9", "key_rdata while open", key_rdata, 32'd0);
                // single-bit near misses (R6)
                apply(1'b1, K ^ 32'h80000000, 1'b0, 4'd0, 1'b0, 32'h0);
                check("R6", "msb flip closes", 32'(unlocked), 32'd0);
                apply(1'b1, K ^ 32'h1, 1'b0, 4'd0, 1'b0, 32'h0);
                check("R1", "lsb flip stays closed", 32'(unlocked), 32'd0);
                // reset while open clears state and sticky bit (R1, R7)
                apply(1'b1, K, 1'b0, 4'd0, 1'b0, 32'h0);
                rst_n = 1'b0;
                @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                check("R1", "closed after re-reset", 32'(unlocked), 32'd0);
                check("R7", "viol cleared by reset", 32'(access_viol), 32'd0);
                disable wd;
            end
        join
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule